// File: doc/BRIEF.md
# Per-Channel Threshold Suppressor with Hit Labelling

This block sits between a multi-channel digitiser and a slower output link. On each cycle with a valid sample it receives one reading from one channel, together with the channel index and the bunch-crossing number. It subtracts that channel's pedestal, clamps negative results to zero, and compares the result with that channel's threshold. A sample whose subtracted value is strictly above the threshold becomes a 48-bit hit word. The word carries the value and a label that holds the channel and the crossing number. Samples at or below the threshold are discarded. Hit words wait in a small FIFO and leave through a ready/valid port, so the link only needs to carry the average hit rate, not the full sample rate.

Two tables of 128 entries, 14 bits each, hold the pedestals and the thresholds. Both are written through a simple configuration port. A monitoring mode turns suppression off. In that mode every valid sample is forwarded with its raw, unsubtracted value, so pedestal and noise can be measured further downstream. When a hit arrives and the FIFO is full, the hit is lost. A saturating drop counter and a sticky drop flag record the loss.

Top module: `hit_suppressor`

## Requirements
- R1: After reset, `hit_valid` is 0, `drop_count` is 0 and `drop_flag` is 0. Every pedestal and threshold entry reads as 0.
- R2: A cycle with `cfg_we`=1 writes `cfg_data` into entry `cfg_addr`. The pedestal table is written when `cfg_sel`=0 and the threshold table when `cfg_sel`=1. A sample in the same cycle as the write still sees the old value; the new value applies from the next cycle.
- R3: The corrected value is `adc - pedestal[chan]` when `adc` > pedestal, and 0 otherwise.
- R4: With `raw_mode`=0, a valid sample makes a hit only if the corrected value is strictly greater than `threshold[chan]`. The hit's sample field holds the corrected value.
- R5: Hit word layout: bits 47:32 hold the sample field, zero-extended from 14 bits. Bits 31:25 hold the channel, bits 24:12 hold the crossing number, and bits 11:0 are 0.
- R6: With `raw_mode`=1, every valid sample makes a hit, and its sample field holds the raw `adc` value.
- R7: Hits leave in arrival order. A hit pushed at a clock edge is visible on `hit_data` after that edge if the FIFO was empty. `hit_valid` and `hit_data` hold while `hit_ready` is low.
- R8: If a hit arises at an edge where the FIFO already holds FIFO_DEPTH entries, the hit is dropped. This holds even if a word leaves at the same edge. `drop_count` then increments and saturates at its all-ones value, and `drop_flag` sets and stays set until reset.
- R9: A cycle with `smp_valid`=0 creates no hit and changes no drop state, whatever the other sample inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 7 | Channel index of the sample |
| smp_adc | input | 14 | Digitised value |
| smp_xing | input | 13 | Bunch-crossing number |
| raw_mode | input | 1 | 1 = forward every sample unsuppressed |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 = pedestal table, 1 = threshold table |
| cfg_addr | input | 7 | Channel entry to write |
| cfg_data | input | 14 | Value to write |
| hit_valid | output | 1 | Hit word available |
| hit_ready | input | 1 | Consumer accepts the hit word |
| hit_data | output | 48 | Hit word (layout in R5) |
| drop_count | output | 8 | Saturating count of lost hits |
| drop_flag | output | 1 | Sticky indication that a hit was lost |

## Verification
The assertions assume that `rst_n` is held low for at least one edge, and that after release every input is a known value that is stable around the rising edge. They make no assumption about when `hit_ready` rises or falls. The bench changes every input only on the falling clock edge. It drives only defined values and toggles `hit_ready` at random, including long stretches with it held low. This exercises the hold and drop properties under real back-pressure, without breaking those assumptions.

// File: rtl/hitlab_pkg.sv
package hitlab_pkg;
  localparam int ADC_W   = 14;
  localparam int CH_W    = 7;
  localparam int XING_W  = 13;
  localparam int SAMP_W  = 16;
  localparam int LABEL_W = 32;
  localparam int WORD_W  = SAMP_W + LABEL_W;
  localparam int RSV_W   = LABEL_W - CH_W - XING_W;
  localparam int NUM_CH  = 1 << CH_W;

  typedef enum logic {TAB_PED = 1'b0, TAB_THR = 1'b1} tab_sel_e;
endpackage

// File: rtl/hitlab_cfg_table.sv
module hitlab_cfg_table #(
  parameter int N  = 128,
  parameter int AW = 7,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hitlab_classify.sv
module hitlab_classify
  import hitlab_pkg::*;
(
  input  logic              valid,
  input  logic              raw_mode,
  input  logic [ADC_W-1:0]  adc,
  input  logic [ADC_W-1:0]  ped,
  input  logic [ADC_W-1:0]  thr,
  output logic              keep,
  output logic [SAMP_W-1:0] samp
);
  logic [ADC_W-1:0] corr;

  always_comb begin
    corr = (adc > ped) ? (adc - ped) : '0;
    keep = valid && (raw_mode || (corr > thr));
    samp = raw_mode ? {{(SAMP_W-ADC_W){1'b0}}, adc}
                    : {{(SAMP_W-ADC_W){1'b0}}, corr};
  end
endmodule

// File: rtl/hitlab_fifo.sv
module hitlab_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] count, count_d;
  logic             do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign dout      = mem[rd_ptr];

  always_comb begin
    do_push  = push && !full;
    do_pop   = out_valid && out_ready;
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (do_push) wr_ptr_d = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    case ({do_push, do_pop})
      2'b10:   count_d = count + 1'b1;
      2'b01:   count_d = count - 1'b1;
      default: count_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  // R7: a presented word is held until taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout)));
  // R8: occupancy never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/hit_suppressor.sv
module hit_suppressor
  import hitlab_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CH_W-1:0]   smp_chan,
  input  logic [ADC_W-1:0]  smp_adc,
  input  logic [XING_W-1:0] smp_xing,
  input  logic              raw_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CH_W-1:0]   cfg_addr,
  input  logic [ADC_W-1:0]  cfg_data,
  output logic              hit_valid,
  input  logic              hit_ready,
  output logic [WORD_W-1:0] hit_data,
  output logic [DROP_W-1:0] drop_count,
  output logic              drop_flag
);
  localparam int NUM_TAB = 2;

  logic              rst_meta, rst_q;
  logic [ADC_W-1:0]  tab_rd [NUM_TAB];
  logic              keep, full, drop;
  logic [SAMP_W-1:0] samp;
  logic [WORD_W-1:0] word;
  logic [DROP_W-1:0] drop_count_d;
  logic              drop_flag_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  for (genvar k = 0; k < NUM_TAB; k++) begin : g_tab
    hitlab_cfg_table #(.N(NUM_CH), .AW(CH_W), .DW(ADC_W)) u_tab (
      .clk   (clk),
      .rst_n (rst_q),
      .we    (cfg_we && (cfg_sel == 1'(k))),
      .waddr (cfg_addr),
      .wdata (cfg_data),
      .raddr (smp_chan),
      .rdata (tab_rd[k])
    );
  end

  hitlab_classify u_cls (
    .valid    (smp_valid),
    .raw_mode (raw_mode),
    .adc      (smp_adc),
    .ped      (tab_rd[TAB_PED]),
    .thr      (tab_rd[TAB_THR]),
    .keep     (keep),
    .samp     (samp)
  );

  assign word = {samp, smp_chan, smp_xing, {RSV_W{1'b0}}};

  hitlab_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (keep),
    .din       (word),
    .full      (full),
    .out_valid (hit_valid),
    .out_ready (hit_ready),
    .dout      (hit_data)
  );

  always_comb begin
    drop         = keep && full;
    drop_count_d = drop_count;
    if (drop && !(&drop_count)) drop_count_d = drop_count + 1'b1;
    drop_flag_d  = drop_flag || drop;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      drop_count <= '0;
      drop_flag  <= 1'b0;
    end else begin
      drop_count <= drop_count_d;
      drop_flag  <= drop_flag_d;
    end
  end

  // R8: the drop counter never goes backwards
  a_r8_count_monotone: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> (drop_count >= $past(drop_count)));
  // R8: the flag is sticky
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    drop_flag |=> drop_flag);
  // R8: a counter increment comes with a raised flag
  a_r8_count_flag: assert property (@(posedge clk) disable iff (!rst_q)
    (drop_count != '0) |-> drop_flag);
  // R5: reserved label bits are zero on every presented word
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_q)
    hit_valid |-> (hit_data[RSV_W-1:0] == '0));
  // R4: a suppressed-mode hit always carries a nonzero corrected value
  a_r4_nonzero_hit: assert property (@(posedge clk) disable iff (!rst_q)
    (keep && !raw_mode) |-> (word[WORD_W-1 -: SAMP_W] != '0));
  // R9: no valid sample, no drop
  a_r9_idle_no_drop: assert property (@(posedge clk) disable iff (!rst_q)
    !smp_valid |=> (drop_count == $past(drop_count)));
endmodule

// File: tb/hit_suppressor_bench.sv
module hit_suppressor_bench;
  localparam int DEPTH    = 16;
  localparam int DROP_MAX = 255;

  logic        clk, rst_n;
  logic        smp_valid, raw_mode, cfg_we, cfg_sel, hit_ready;
  logic [6:0]  smp_chan, cfg_addr;
  logic [13:0] smp_adc, cfg_data;
  logic [12:0] smp_xing;
  logic        hit_valid, drop_flag;
  logic [47:0] hit_data;
  logic [7:0]  drop_count;

  hit_suppressor u_hit_suppressor (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_adc(smp_adc), .smp_xing(smp_xing), .raw_mode(raw_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_data(hit_data),
    .drop_count(drop_count), .drop_flag(drop_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int          checks = 0, failures = 0;
  bit          done = 0;
  string       req = "R1";
  int          m_ped [128];
  int          m_thr [128];
  logic [47:0] m_q [$];
  int          m_drops = 0;
  bit          m_flag = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("hit_valid", 64'(hit_valid), 64'(m_q.size() > 0));
    if (m_q.size() > 0) chk("hit_data", 64'(hit_data), 64'(m_q[0]));
    chk("drop_count", 64'(drop_count), 64'(m_drops));
    chk("drop_flag", 64'(drop_flag), 64'(m_flag));
  endtask

  // one cycle: check outputs, drive inputs, advance the model by one edge
  task automatic cyc(input bit v, input int ch, input int adc, input int xg,
                     input bit raw, input bit rdy,
                     input bit we = 0, input bit sel = 0, input int wa = 0, input int wd = 0);
    int  corr;
    bit  keep, full;
    compare_all();
    smp_valid = v; smp_chan = 7'(ch); smp_adc = 14'(adc); smp_xing = 13'(xg);
    raw_mode = raw; hit_ready = rdy;
    cfg_we = we; cfg_sel = sel; cfg_addr = 7'(wa); cfg_data = 14'(wd);
    corr = (adc > m_ped[ch]) ? adc - m_ped[ch] : 0;
    keep = v && (raw || corr > m_thr[ch]);
    full = (m_q.size() == DEPTH);
    if (rdy && m_q.size() > 0) void'(m_q.pop_front());
    if (keep) begin
      if (full) begin
        m_flag = 1;
        if (m_drops < DROP_MAX) m_drops++;
      end else begin
        m_q.push_back({16'(raw ? adc : corr), 7'(ch), 13'(xg), 12'h000});
      end
    end
    if (we) begin
      if (sel) m_thr[wa] = wd; else m_ped[wa] = wd;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_ped[i] = 0; m_thr[i] = 0; end
    rst_n = 1'b0; smp_valid = 0; smp_chan = 0; smp_adc = 0; smp_xing = 0;
    raw_mode = 0; cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_data = 0; hit_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state; zero tables mean corrected 1 > 0 keeps, 0 does not
    req = "R1";
    compare_all();
    cyc(1, 9, 0, 1, 0, 0);
    cyc(1, 9, 1, 2, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R2 R3 R4: table writes, clamp, strict comparison
    req = "R2 R3 R4";
    cyc(0, 0, 0, 0, 0, 1, 1, 0, 5, 100);
    cyc(0, 0, 0, 0, 0, 1, 1, 1, 5, 20);
    cyc(1, 5, 120, 10, 0, 1);   // corrected 20, equal: dropped
    cyc(1, 5, 121, 11, 0, 1);   // 21: kept
    cyc(1, 5, 50, 12, 0, 1);    // clamps to 0
    cyc(1, 5, 101, 13, 0, 1, 1, 1, 5, 0);  // old threshold 20 applies
    cyc(1, 5, 101, 14, 0, 1);   // new threshold 0: kept
    cyc(1, 5, 100, 15, 0, 1);   // corrected 0: not kept
    cyc(0, 0, 0, 0, 0, 1);

    // R5: label fields at extreme values
    req = "R5";
    cyc(1, 127, 16383, 8191, 0, 1);
    cyc(1, 0, 16383, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R9: invalid samples leave no trace
    req = "R9";
    for (int i = 0; i < 20; i++) cyc(0, i, 16383, i, 1, 1);

    // R6: monitoring mode forwards everything raw
    req = "R6";
    for (int i = 0; i < 40; i++) cyc(1, i % 8, $urandom_range(0, 200), i, 1, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R2 R4 R7: random tables, random samples, random back-pressure
    req = "R2 R4 R7";
    for (int c = 0; c < 32; c++) begin
      cyc(0, 0, 0, 0, 0, 1, 1, 0, c, $urandom_range(0, 400));
      cyc(0, 0, 0, 0, 0, 1, 1, 1, c, $urandom_range(0, 60));
    end
    for (int i = 0; i < 3000; i++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 31), $urandom_range(0, 500),
          i, $urandom_range(0, 9) == 0, $urandom_range(0, 2) != 0);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 1);

    // R8: fill, overflow with pop at the same edge, saturate, sticky flag
    req = "R8";
    for (int i = 0; i < DEPTH; i++) cyc(1, 1, 7, i, 1, 0);
    cyc(1, 2, 8, 100, 1, 1);    // full at edge while popping: dropped
    cyc(1, 2, 9, 101, 1, 0);    // one slot free: stored
    for (int i = 0; i < 300; i++) cyc(1, 3, i, i, 1, 0);
    chk("drop_count saturated", 64'(drop_count), 64'(DROP_MAX));
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 0, 1);
    chk("drop_flag sticky", 64'(drop_flag), 64'd1);
    chk("drained", 64'(hit_valid), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule